// File: doc/BRIEF.md
# HDLC Receive Frame Collector

This block gathers the bytes of received D-channel frames from a small receive FIFO into a linear frame buffer. Two event strobes drive it. A pool-full event means the FIFO holds a complete block of bytes. A message-end event means the FIFO holds the tail of a frame, with a residual byte count and a set of status flags. For each event the block copies the bytes one per cycle. It then acknowledges the FIFO with a single release strobe. When the tail has been copied, it announces the finished frame with a one-cycle valid pulse that carries the frame length.

A frame is accepted only when its status flags match one exact pattern. Frames that fail this check, or that would not fit in the buffer, are discarded. A discarded frame is still acknowledged to the FIFO, and the collection index returns to zero. In the extended mode, the receiver appends a status byte to every frame. The block then also requires the valid-frame flag and leaves that trailing byte out of the delivered length. CRC computation and flag detection happen upstream.

Top module: `hdlc_rx_collector`

## Requirements
- R1: A pool-full event with no overflow copies exactly FIFO_DEPTH (32) bytes, from FIFO addresses 0 upward, into the buffer starting at the current index. It then gives exactly one release pulse, and the index advances by 32.
- R2: In normal mode a message end is accepted only when rx_flags[2:0] (bit 2 overflow, bit 1 CRC good, bit 0 aborted) equals 3'b010. Any other value reads no byte, gives one release pulse, gives no frame pulse and clears the index.
- R3: In extended mode (ext_mode=1) a message end is accepted only when rx_flags equals 4'b1010, where bit 3 is the valid-frame flag. Otherwise it is dropped exactly as in R2.
- R4: The residual byte count of a message end is rx_count (5 bits). A value of 0 stands for 32 bytes.
- R5: If the index plus the incoming byte count is at least MAX_LEN (300), no byte is read and one release pulse is given. No frame pulse follows, and the index returns to zero. A sum of MAX_LEN-1 is still accepted.
- R6: In normal mode an accepted message end gives one frame_valid pulse in the same cycle as its release pulse. frame_len equals the total bytes collected since the index was last cleared.
- R7: In extended mode the delivered length is the collected total minus one. A total of one byte gives no frame_valid pulse.
- R8: The index returns to zero after every message end, whether the frame was kept or dropped.
- R9: Event strobes that arrive while busy is high are ignored. When both strobes are high in the same idle cycle, the message end is handled and the pool-full is ignored.
- R10: Copying moves one byte per cycle. The byte read at FIFO address k is written at buffer address index+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | Extended mode: trailing status byte and valid-frame flag |
| pool_full | input | 1 | Strobe: FIFO holds a full block |
| msg_end | input | 1 | Strobe: FIFO holds the end of a frame |
| rx_flags | input | 4 | Status flags {valid, overflow, crc_ok, aborted} |
| rx_count | input | 5 | Residual byte count, 0 means 32 |
| fifo_addr | output | 5 | FIFO read address |
| fifo_rd | output | 1 | FIFO read in this cycle |
| fifo_data | input | 8 | FIFO read data for fifo_addr (combinational) |
| buf_we | output | 1 | Frame buffer write enable |
| buf_addr | output | 9 | Frame buffer write address |
| buf_data | output | 8 | Frame buffer write data |
| frame_valid | output | 1 | One-cycle pulse: a good frame is complete |
| frame_len | output | 9 | Length of the delivered frame |
| release_cmd | output | 1 | One-cycle FIFO release command |
| busy | output | 1 | Copy in progress, events ignored |

## Verification
Every flag combination is applied in both modes. This shows whether the normal check ignores the valid-frame flag and whether the extended check requires it. Residual counts of 0, 1, 2 and mid-range values separate the 0-means-32 rule from the strip-one rule at its edge. Chains of pool-full blocks that end at 299 and 300 bytes find where the overflow comparison lies. Strobes injected during a copy, and both strobes raised together, test the ignore and priority rules. Random event streams with random FIFO contents then compare every written byte and every delivered length against a bench model.

// File: rtl/hdlc_rx_collector.sv
`timescale 1ns/1ps
module hdlc_rx_collector #(
  parameter int MAX_LEN    = 300,
  parameter int FIFO_DEPTH = 32,
  localparam int AW    = $clog2(FIFO_DEPTH),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int IDX_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             pool_full,
  input  logic             msg_end,
  input  logic [3:0]       rx_flags,
  input  logic [AW-1:0]    rx_count,
  output logic [AW-1:0]    fifo_addr,
  output logic             fifo_rd,
  input  logic [7:0]       fifo_data,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_addr,
  output logic [7:0]       buf_data,
  output logic             frame_valid,
  output logic [IDX_W-1:0] frame_len,
  output logic             release_cmd,
  output logic             busy
);

  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] k, n;
  logic             end_r, ext_r;

  wire              flags_ok = ext_mode ? (rx_flags == 4'b1010) : (rx_flags[2:0] == 3'b010);
  wire [CNT_W-1:0]  resid    = (rx_count == '0) ? CNT_W'(FIFO_DEPTH) : CNT_W'(rx_count);
  wire [CNT_W-1:0]  want     = msg_end ? resid : CNT_W'(FIFO_DEPTH);
  wire [IDX_W:0]    reach    = {1'b0, idx} + (IDX_W+1)'(want);
  wire              over     = reach >= (IDX_W+1)'(MAX_LEN);
  wire              start    = !busy && (pool_full || msg_end);
  wire              drop     = (msg_end && !flags_ok) || over;

  wire              last     = (k == n - CNT_W'(1));
  wire [IDX_W-1:0]  total    = idx + IDX_W'(n);
  wire [IDX_W-1:0]  len      = ext_r ? total - IDX_W'(1) : total;
  wire              len_ok   = !ext_r || (total > IDX_W'(1));

  assign fifo_rd   = busy;
  assign fifo_addr = k[AW-1:0];
  assign buf_we    = busy;
  assign buf_addr  = idx + IDX_W'(k);
  assign buf_data  = fifo_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idx         <= '0;
      k           <= '0;
      n           <= '0;
      end_r       <= 1'b0;
      ext_r       <= 1'b0;
      release_cmd <= 1'b0;
      frame_valid <= 1'b0;
      frame_len   <= '0;
    end else begin
      release_cmd <= 1'b0;
      frame_valid <= 1'b0;
      if (start) begin
        if (drop) begin
          release_cmd <= 1'b1;
          idx         <= '0;
        end else begin
          busy  <= 1'b1;
          k     <= '0;
          n     <= want;
          end_r <= msg_end;
          ext_r <= ext_mode;
        end
      end else if (busy) begin
        k <= k + CNT_W'(1);
        if (last) begin
          busy        <= 1'b0;
          release_cmd <= 1'b1;
          if (end_r) begin
            idx         <= '0;
            frame_valid <= len_ok;
            frame_len   <= len;
          end else begin
            idx <= total;
          end
        end
      end
    end
  end

endmodule

module hdlc_rx_collector_chk #(
  parameter int MAX_LEN = 300,
  parameter int AW      = 5,
  parameter int IDX_W   = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_end,
  input logic [3:0]       rx_flags,
  input logic [AW-1:0]    fifo_addr,
  input logic             fifo_rd,
  input logic             buf_we,
  input logic [IDX_W-1:0] buf_addr,
  input logic             frame_valid,
  input logic [IDX_W-1:0] frame_len,
  input logic             release_cmd,
  input logic             busy
);

  AST_FRAME_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> release_cmd); // R6

  AST_FRAME_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (frame_len != '0) && (frame_len < IDX_W'(MAX_LEN))); // R7

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && msg_end && rx_flags[0]) |=> (release_cmd && !busy && !frame_valid)); // R2

  AST_BUF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_addr < IDX_W'(MAX_LEN))); // R5

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && $past(fifo_rd)) |-> (fifo_addr == $past(fifo_addr) + AW'(1))); // R10

  AST_COPY_ENDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> release_cmd); // R1

  AST_FRAME_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(busy)); // R8

endmodule

bind hdlc_rx_collector hdlc_rx_collector_chk #(.MAX_LEN(MAX_LEN), .AW(AW), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .msg_end(msg_end), .rx_flags(rx_flags),
  .fifo_addr(fifo_addr), .fifo_rd(fifo_rd), .buf_we(buf_we), .buf_addr(buf_addr),
  .frame_valid(frame_valid), .frame_len(frame_len), .release_cmd(release_cmd), .busy(busy)
);

// File: tb/test_hdlc_rx_collector.sv
`timescale 1ns/1ps
module test_hdlc_rx_collector;
  localparam int MAX_LEN = 300;
  localparam int DEPTH   = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0, pool_full = 1'b0, msg_end = 1'b0;
  logic [3:0] rx_flags = 4'h0;
  logic [4:0] rx_count = 5'h0;
  logic [4:0] fifo_addr;
  logic       fifo_rd, buf_we, frame_valid, release_cmd, busy;
  logic [8:0] buf_addr, frame_len;
  logic [7:0] buf_data, fifo_data;

  logic [7:0] fifo_mem [0:DEPTH-1];
  logic [7:0] buf_mem  [0:MAX_LEN-1];
  int rd_cnt, rel_cnt, fv_cnt, got_len;
  int checks = 0, fails = 0;
  int exp_idx = 0;

  always #10 clk = ~clk;

  assign fifo_data = fifo_mem[fifo_addr];

  hdlc_rx_collector i_hdlc_rx_collector (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .pool_full(pool_full), .msg_end(msg_end),
    .rx_flags(rx_flags), .rx_count(rx_count), .fifo_addr(fifo_addr), .fifo_rd(fifo_rd),
    .fifo_data(fifo_data), .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .frame_valid(frame_valid), .frame_len(frame_len), .release_cmd(release_cmd), .busy(busy)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (fifo_rd) rd_cnt++;
      if (buf_we && buf_addr < MAX_LEN) buf_mem[buf_addr] = buf_data;
      if (release_cmd) rel_cnt++;
      if (frame_valid) begin fv_cnt++; got_len = frame_len; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit flags_good(input logic [3:0] f, input bit ext);
    return ext ? (f == 4'b1010) : (f[2:0] == 3'b010);
  endfunction

  function automatic int resid(input logic [4:0] c);
    return (c == 0) ? DEPTH : int'(c);
  endfunction

  task automatic send(input bit pf, input bit me, input logic [3:0] fl, input logic [4:0] cnt,
                      input bit ext, input bit inject, input string tag);
    int n, reads, exp_fv, exp_len, old, mism;
    bit drop;
    for (int i = 0; i < DEPTH; i++) fifo_mem[i] = 8'($urandom);
    old  = exp_idx;
    n    = me ? resid(cnt) : DEPTH;
    drop = (me && !flags_good(fl, ext)) || (exp_idx + n >= MAX_LEN);
    reads = drop ? 0 : n;
    exp_fv = 0; exp_len = 0;
    if (drop) exp_idx = 0;
    else begin
      exp_idx += n;
      if (me) begin
        exp_len = ext ? exp_idx - 1 : exp_idx;
        exp_fv  = (exp_len >= 1);
        exp_idx = 0;
      end
    end
    rd_cnt = 0; rel_cnt = 0; fv_cnt = 0; got_len = -1;
    @(negedge clk);
    pool_full = pf; msg_end = me; rx_flags = fl; rx_count = cnt; ext_mode = ext;
    @(negedge clk);
    pool_full = 0; msg_end = 0;
    if (inject) begin
      repeat (3) @(negedge clk);
      msg_end = 1; pool_full = 1; rx_flags = 4'b0001;
      @(negedge clk);
      msg_end = 0; pool_full = 0;
    end
    repeat (38) @(negedge clk);
    check(rel_cnt == 1, {tag, " release count"}, rel_cnt, 1);
    check(rd_cnt == reads, {tag, " bytes read"}, rd_cnt, reads);
    check(fv_cnt == exp_fv, {tag, " frame pulses"}, fv_cnt, exp_fv);
    if (exp_fv == 1) check(got_len == exp_len, {tag, " frame length"}, got_len, exp_len);
    mism = 0;
    for (int i = 0; i < reads; i++) if (buf_mem[old + i] !== fifo_mem[i]) mism++;
    check(mism == 0, {tag, " R10 byte placement mismatches"}, mism, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #3_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check({busy, release_cmd, frame_valid, fifo_rd, buf_we} == 5'b0, "reset outputs idle",
          int'({busy, release_cmd, frame_valid, fifo_rd, buf_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(0, 1, 4'b0010, 5'd5, 0, 0, "R2 R6 good normal frame");
    send(0, 1, 4'b0110, 5'd5, 0, 0, "R2 overflow flag drop");
    send(0, 1, 4'b0000, 5'd5, 0, 0, "R2 crc bad drop");
    send(0, 1, 4'b0011, 5'd5, 0, 0, "R2 abort drop");
    send(0, 1, 4'b1010, 5'd7, 0, 0, "R2 valid flag ignored in normal mode");
    send(0, 1, 4'b0010, 5'd5, 1, 0, "R3 ext without valid flag drop");
    send(0, 1, 4'b1011, 5'd5, 1, 0, "R3 ext abort drop");
    send(0, 1, 4'b1010, 5'd6, 1, 0, "R3 R7 ext good frame");
    send(0, 1, 4'b1010, 5'd1, 1, 0, "R7 ext single byte no frame");
    send(0, 1, 4'b1010, 5'd2, 1, 0, "R7 ext two bytes");
    send(0, 1, 4'b0010, 5'd0, 0, 0, "R4 zero count means 32");
    send(0, 1, 4'b1010, 5'd0, 1, 0, "R4 R7 ext zero count");
    send(1, 0, 4'b0000, 5'd0, 0, 0, "R1 pool full block");
    send(0, 1, 4'b0010, 5'd4, 0, 0, "R1 R6 frame after pool");
    for (int i = 0; i < 9; i++) send(1, 0, 4'b0000, 5'd0, 0, 0, "R1 chain");
    send(0, 1, 4'b0010, 5'd11, 0, 0, "R5 length 299 accepted");
    for (int i = 0; i < 9; i++) send(1, 0, 4'b0000, 5'd0, 0, 0, "R1 chain");
    send(0, 1, 4'b0010, 5'd12, 0, 0, "R5 reaching 300 dropped");
    send(0, 1, 4'b0010, 5'd2, 0, 0, "R5 R8 index cleared after overflow");
    for (int i = 0; i < 9; i++) send(1, 0, 4'b0000, 5'd0, 0, 0, "R1 chain");
    send(1, 0, 4'b0000, 5'd0, 0, 0, "R5 pool full overflow");
    send(0, 1, 4'b0010, 5'd3, 0, 0, "R5 index cleared after pool overflow");
    send(1, 0, 4'b0000, 5'd0, 0, 1, "R9 strobes ignored while busy");
    send(0, 1, 4'b0010, 5'd1, 0, 0, "R9 collection continued");
    send(1, 1, 4'b0010, 5'd3, 0, 0, "R9 message end wins");
    send(1, 0, 4'b0000, 5'd0, 0, 0, "R8 pool before drop");
    send(0, 1, 4'b0100, 5'd3, 0, 0, "R8 drop clears index");
    send(0, 1, 4'b0010, 5'd1, 0, 0, "R8 next frame starts at zero");

    for (int i = 0; i < 70; i++) begin
      bit pf, me, ext;
      logic [3:0] fl;
      pf  = ($urandom % 3) == 0;
      me  = !pf || (($urandom % 4) == 0);
      ext = $urandom % 2;
      fl  = (($urandom % 4) != 0) ? (ext ? 4'b1010 : {1'($urandom), 3'b010}) : 4'($urandom);
      send(pf, me, fl, 5'($urandom), ext, 0, "R6 R7 random");
    end
    summary();
  end
endmodule